// File: doc/BRIEF.md
# Guarded Windowed Watchdog

This block is a watchdog timer with a 32-bit register port. A down-counter loads from a programmable time-out value. While the watchdog is on, software must restart the counter with a fixed two-word service sequence before the count runs out. The first expiry raises an interrupt. A second expiry, while that interrupt is still pending, raises a one-cycle system reset request. A window mode can also reject a service that comes too early.

Every register access is checked. An access is rejected when it has the wrong size or bad alignment, targets a reserved offset, comes from a requester without permission, goes against a register's direction, or writes a wrong service word while the watchdog runs. A rejected access changes no register. A control bit picks how it is answered: with a bus error response, or with a system reset request. A soft lock and a hard lock freeze the configuration. The soft lock is released by a two-word unlock sequence. The hard lock is released only by reset.

Every request is answered one cycle later on the response port.

Top module: `guarded_watchdog`

## Requirements
- R1: The registers sit at word offsets 0x00 control, 0x04 interrupt, 0x08 time-out, 0x0C window, 0x10 service, 0x14 counter, 0x18 key. After reset they read 0xFF000103, 0, 0x00027100, 0, (service is write-only), counter, 0. In the control register, bit 0 enables, bit 4 is the soft lock, bit 5 is the hard lock, bit 6 turns on window mode and bit 8 selects reset on an invalid access. Each request gets exactly one response in the following cycle.
- R2: req_size encodes 0 as byte, 1 as halfword and 2 as word. Any access whose size is not word is invalid.
- R3: These accesses are invalid: one with req_master_ok low, one to an offset above 0x18, and one whose two low address bits are not zero.
- R4: A write to the counter register and a read of the service register are invalid. An invalid access returns read data zero and changes no register.
- R5: When control bit 8 is 0, an invalid access is answered with rsp_err high. When bit 8 is 1, rsp_err stays low and sys_reset_req pulses in the response cycle.
- R6: While the soft lock is set, writes to the control, time-out, window and key registers are invalid. Writing 0xC520 and then 0xD928 to the service register clears the soft lock.
- R7: While the hard lock is set, the same four registers refuse writes. The unlock sequence does not clear the hard lock; only reset clears it.
- R8: While disabled, the counter holds the time-out value. While enabled, it counts down by one each cycle. The counter register reads its value.
- R9: When the count first reaches zero, it sets interrupt bit 0 (cleared by writing 1), drives irq high and reloads. When the count reaches zero again while that flag is still set, sys_reset_req pulses for one cycle.
- R10: Writing 0xA602 and then 0xB480 to the service register reloads the counter from the time-out value.
- R11: While the watchdog is enabled, any other service word, or 0xB480 or 0xD928 out of sequence, is invalid and aborts a partly completed sequence. While the watchdog is disabled, such a word causes no error.
- R12: With window mode on, a service that completes while the counter is above the window value is invalid and does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset in the block |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_master_ok | input | 1 | Requester has permission |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Bus error for that request |
| rsp_rdata | output | 32 | Read data, zero on error |
| sys_reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Time-out interrupt flag |

## Verification
A wrong sequence state shows up within two accesses. Either a valid service is refused or a wrong word is accepted, and the next response carries an unexpected error or reset flag. A wrong lock or policy bit shows up in the response to the very next write to a guarded register. A counter fault does not show at once: it is seen only one time-out period later, as an interrupt or reset pulse that comes too early or never comes. For this reason the bench samples irq and counts reset pulses in windows placed around each expected expiry.

// File: rtl/gwd_pkg.sv
package gwd_pkg;

    localparam int unsigned DW = 32;

    typedef enum logic [2:0] {
        REG_CTL  = 3'd0,
        REG_IRQ  = 3'd1,
        REG_TMO  = 3'd2,
        REG_WIN  = 3'd3,
        REG_SVC  = 3'd4,
        REG_CNT  = 3'd5,
        REG_KEY  = 3'd6,
        REG_NONE = 3'd7
    } reg_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SVC,
        SEQ_UNL
    } seq_e;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam int unsigned B_EN  = 0;
    localparam int unsigned B_SLK = 4;
    localparam int unsigned B_HLK = 5;
    localparam int unsigned B_WND = 6;
    localparam int unsigned B_RIA = 8;

    localparam logic [DW-1:0] KEY_SVC_A = 32'h0000_A602;
    localparam logic [DW-1:0] KEY_SVC_B = 32'h0000_B480;
    localparam logic [DW-1:0] KEY_UNL_A = 32'h0000_C520;
    localparam logic [DW-1:0] KEY_UNL_B = 32'h0000_D928;

    typedef struct packed {
        logic [DW-1:0] cr;
        logic          flag;
        logic [DW-1:0] tmo;
        logic [DW-1:0] win;
        logic [DW-1:0] key;
        seq_e          seq;
        logic          rsp_v;
        logic          rsp_e;
        logic [DW-1:0] rsp_d;
        logic          rst;
    } gwd_state_t;

endpackage

// File: rtl/gwd_decode.sv
module gwd_decode
    import gwd_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic              master_ok,
    input  logic              locked,
    output reg_e              sel,
    output logic              fmt_bad,
    output logic              dir_bad
);
    localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(24);

    logic reserved;
    logic guarded;

    always_comb begin
        reserved = (addr[1:0] != 2'b00) || (addr > LAST_OFF);
        sel      = reserved ? REG_NONE : reg_e'(addr[4:2]);
        fmt_bad  = reserved || (size != SIZE_WORD) || !master_ok;
        guarded  = (sel == REG_CTL) || (sel == REG_TMO) ||
                   (sel == REG_WIN) || (sel == REG_KEY);
        dir_bad  = (write && sel == REG_CNT) ||
                   (write && locked && guarded) ||
                   (!write && sel == REG_SVC);
    end

endmodule

// File: rtl/gwd_counter.sv
module gwd_counter #(
    parameter int unsigned   W    = 32,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         reload,
    input  logic         flag_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         set_flag,
    output logic         bite
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         hit;

    always_comb begin
        hit      = en && (cnt_q == '0) && !reload;
        set_flag = hit && !flag_in;
        bite     = hit && flag_in;
        if (!en || reload || hit) begin
            cnt_d = load_val;
        end else begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= INIT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/guarded_watchdog.sv
module guarded_watchdog
    import gwd_pkg::*;
#(
    parameter int unsigned    ADDR_W  = 14,
    parameter logic [DW-1:0]  CR_RST  = 32'hFF00_0103,
    parameter logic [DW-1:0]  TMO_RST = 32'h0002_7100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_master_ok,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic              sys_reset_req,
    output logic              irq
);
    gwd_state_t q, d;

    reg_e          sel;
    logic          fmt_bad, dir_bad;
    logic          svc_bad, reload, unlock;
    seq_e          seq_next;
    logic [DW-1:0] cnt;
    logic          cnt_set_flag, cnt_bite;

    logic          en, win_on, ria, hard_lock, any_lock;
    logic [DW-1:0] to_val;

    assign en        = q.cr[B_EN];
    assign win_on    = q.cr[B_WND];
    assign ria       = q.cr[B_RIA];
    assign hard_lock = q.cr[B_HLK];
    assign any_lock  = q.cr[B_HLK] | q.cr[B_SLK];
    assign to_val    = q.tmo;

    gwd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (req_addr),
        .size      (req_size),
        .write     (req_write),
        .master_ok (req_master_ok),
        .locked    (any_lock),
        .sel       (sel),
        .fmt_bad   (fmt_bad),
        .dir_bad   (dir_bad)
    );

    gwd_counter #(.W(DW), .INIT(TMO_RST)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .reload   (reload),
        .flag_in  (q.flag),
        .load_val (q.tmo),
        .cnt      (cnt),
        .set_flag (cnt_set_flag),
        .bite     (cnt_bite)
    );

    // service and unlock sequence decode
    always_comb begin
        svc_bad  = 1'b0;
        reload   = 1'b0;
        unlock   = 1'b0;
        seq_next = q.seq;
        if (req_valid && req_write && !fmt_bad && !dir_bad && sel == REG_SVC) begin
            case (req_wdata)
                KEY_SVC_A: seq_next = SEQ_SVC;
                KEY_UNL_A: seq_next = SEQ_UNL;
                KEY_SVC_B: begin
                    seq_next = SEQ_IDLE;
                    if (q.seq == SEQ_SVC && !(win_on && cnt > q.win)) begin
                        reload = 1'b1;
                    end else begin
                        svc_bad = en;
                    end
                end
                KEY_UNL_B: begin
                    seq_next = SEQ_IDLE;
                    if (q.seq == SEQ_UNL) begin
                        unlock = 1'b1;
                    end else begin
                        svc_bad = en;
                    end
                end
                default: begin
                    seq_next = SEQ_IDLE;
                    svc_bad  = en;
                end
            endcase
        end
    end

    // register file and response
    always_comb begin
        d       = q;
        d.rsp_v = req_valid;
        d.rsp_e = 1'b0;
        d.rsp_d = '0;
        d.rst   = cnt_bite;
        d.seq   = seq_next;
        if (cnt_set_flag) begin
            d.flag = 1'b1;
        end
        if (req_valid && (fmt_bad || dir_bad || svc_bad)) begin
            d.rsp_e = !ria;
            if (ria) begin
                d.rst = 1'b1;
            end
        end else if (req_valid && req_write) begin
            case (sel)
                REG_CTL: d.cr   = req_wdata;
                REG_IRQ: if (req_wdata[0]) d.flag = cnt_set_flag;
                REG_TMO: d.tmo  = req_wdata;
                REG_WIN: d.win  = req_wdata;
                REG_KEY: d.key  = req_wdata;
                REG_SVC: if (unlock) d.cr[B_SLK] = 1'b0;
                default: ;
            endcase
        end else if (req_valid) begin
            case (sel)
                REG_CTL: d.rsp_d = q.cr;
                REG_IRQ: d.rsp_d = {{(DW-1){1'b0}}, q.flag};
                REG_TMO: d.rsp_d = q.tmo;
                REG_WIN: d.rsp_d = q.win;
                REG_CNT: d.rsp_d = cnt;
                REG_KEY: d.rsp_d = q.key;
                default: d.rsp_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cr    <= CR_RST;
            q.flag  <= 1'b0;
            q.tmo   <= TMO_RST;
            q.win   <= '0;
            q.key   <= '0;
            q.seq   <= SEQ_IDLE;
            q.rsp_v <= 1'b0;
            q.rsp_e <= 1'b0;
            q.rsp_d <= '0;
            q.rst   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid     = q.rsp_v;
    assign rsp_err       = q.rsp_e;
    assign rsp_rdata     = q.rsp_d;
    assign sys_reset_req = q.rst;
    assign irq           = q.flag;

endmodule

// File: rtl/gwd_checker.sv
module gwd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        ria,
    input logic        hard_lock,
    input logic        any_lock,
    input logic [31:0] to_val,
    input logic        cnt_bite
);
    assert_rsp_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

    assert_err_policy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !$past(ria));

    assert_locked_tmo_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock |=> $stable(to_val));

    assert_hard_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hard_lock |=> hard_lock);

    assert_bite_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_bite |=> !cnt_bite);
endmodule

bind guarded_watchdog gwd_checker u_gwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ria       (ria),
    .hard_lock (hard_lock),
    .any_lock  (any_lock),
    .to_val    (to_val),
    .cnt_bite  (cnt_bite)
);

// File: tb/guarded_watchdog_bench.sv
module guarded_watchdog_bench;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic              req_master_ok = 1'b1;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err, sys_reset_req, irq;
    logic [31:0]       rsp_rdata;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        logic        rst;
        string       tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [13:0] A_CTL = 14'h00, A_IRQ = 14'h04, A_TMO = 14'h08,
                            A_WIN = 14'h0C, A_SVC = 14'h10, A_CNT = 14'h14,
                            A_KEY = 14'h18;

    always #4 clk = ~clk;

    guarded_watchdog #(.ADDR_W(ADDR_W)) u_guarded_watchdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_master_ok (req_master_ok),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_rdata     (rsp_rdata),
        .sys_reset_req (sys_reset_req),
        .irq           (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n) begin
            if (sys_reset_req) rst_seen++;
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R1 unexpected response", rsp_rdata, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
                    chk(rsp_err == e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
                    chk(sys_reset_req == e.rst, {e.tag, " rst"}, 32'(sys_reset_req), 32'(e.rst));
                end
            end
        end
    end

    // driver: one access, expected response pushed to scoreboard
    task automatic acc(input bit wr, input logic [13:0] a, input logic [31:0] wd,
                       input logic [1:0] sz, input bit ok,
                       input logic [31:0] ed, input bit ee, input bit er, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        req_size = sz; req_master_ok = ok;
        e.data = ed; e.err = ee; e.rst = er; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2; req_master_ok = 1'b1;
    endtask

    task automatic wr_ok(input logic [13:0] a, input logic [31:0] wd, input string tag);
        acc(1'b1, a, wd, 2'd2, 1'b1, 32'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd_ok(input logic [13:0] a, input logic [31:0] ed, input string tag);
        acc(1'b0, a, 32'h0, 2'd2, 1'b1, ed, 1'b0, 1'b0, tag);
    endtask

    // each invalid class; er selects reset policy expectation
    task automatic bad_classes(input bit rp, input string pol);
        acc(1'b0, A_CTL, 0, 2'd0, 1'b1, 0, !rp, rp, {"R2 byte read ", pol});
        acc(1'b1, A_TMO, 32'h5, 2'd1, 1'b1, 0, !rp, rp, {"R2 half write ", pol});
        acc(1'b0, A_CTL, 0, 2'd2, 1'b0, 0, !rp, rp, {"R3 no permission ", pol});
        acc(1'b0, 14'h1C, 0, 2'd2, 1'b1, 0, !rp, rp, {"R3 reserved 0x1C ", pol});
        acc(1'b0, 14'h3FFC, 0, 2'd2, 1'b1, 0, !rp, rp, {"R3 reserved top ", pol});
        acc(1'b0, 14'h02, 0, 2'd2, 1'b1, 0, !rp, rp, {"R3 unaligned ", pol});
        acc(1'b1, A_CNT, 32'h7, 2'd2, 1'b1, 0, !rp, rp, {"R4 write counter ", pol});
        acc(1'b0, A_SVC, 0, 2'd2, 1'b1, 0, !rp, rp, {"R4 read service ", pol});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);

        // R1 reset values
        rd_ok(A_CTL, 32'hFF00_0103, "R1 reset control");
        rd_ok(A_IRQ, 32'h0, "R1 reset irq");
        rd_ok(A_TMO, 32'h0002_7100, "R1 reset timeout");
        rd_ok(A_WIN, 32'h0, "R1 reset window");
        rd_ok(A_KEY, 32'h0, "R1 reset key");

        // disable, bus-error policy, short timeout
        wr_ok(A_CTL, 32'h0, "R1 write control");
        wr_ok(A_TMO, 32'd40, "R1 write timeout");
        repeat (2) @(negedge clk);
        rd_ok(A_CNT, 32'd40, "R8 disabled counter holds timeout");

        bad_classes(1'b0, "bus-error");
        rd_ok(A_TMO, 32'd40, "R4 invalid write left timeout");

        wr_ok(A_CTL, 32'h100, "R5 set reset policy");
        bad_classes(1'b1, "reset");
        wr_ok(A_CTL, 32'h0, "R5 clear reset policy");

        // R11 disabled: wrong service word ignored
        wr_ok(A_SVC, 32'h77, "R11 wrong word while disabled");

        // R6 soft lock
        wr_ok(A_CTL, 32'h10, "R6 set soft lock");
        acc(1'b1, A_TMO, 32'd99, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R6 locked timeout write");
        acc(1'b1, A_WIN, 32'd5, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R6 locked window write");
        acc(1'b1, A_KEY, 32'd5, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R6 locked key write");
        acc(1'b1, A_CTL, 32'h0, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R6 locked control write");
        rd_ok(A_TMO, 32'd40, "R6 timeout unchanged");
        wr_ok(A_SVC, 32'hC520, "R6 unlock first");
        wr_ok(A_SVC, 32'hD928, "R6 unlock second");
        rd_ok(A_CTL, 32'h0, "R6 soft lock cleared");
        wr_ok(A_KEY, 32'h1234, "R6 key writable again");
        rd_ok(A_KEY, 32'h1234, "R6 key readback");

        // R8/R9 time-out, interrupt then reset
        base = rst_seen;
        wr_ok(A_CTL, 32'h1, "R8 enable");
        repeat (30) @(negedge clk);
        chk(irq == 1'b0, "R9 no irq before expiry", 32'(irq), 0);
        repeat (20) @(negedge clk);
        chk(irq == 1'b1, "R9 irq after first expiry", 32'(irq), 1);
        chk(rst_seen == base, "R9 no reset on first expiry", rst_seen, base);
        rd_ok(A_IRQ, 32'h1, "R9 irq flag reads 1");
        repeat (45) @(negedge clk);
        chk(rst_seen == base + 1, "R9 one reset pulse on second expiry", rst_seen, base + 1);
        wr_ok(A_IRQ, 32'h1, "R9 clear flag");
        chk(irq == 1'b0, "R9 irq cleared by write 1", 32'(irq), 0);
        wr_ok(A_CTL, 32'h0, "R8 disable");

        // R10 service keeps it alive
        base = rst_seen;
        wr_ok(A_CTL, 32'h1, "R10 enable");
        for (int i = 0; i < 4; i++) begin
            repeat (25) @(negedge clk);
            wr_ok(A_SVC, 32'hA602, "R10 service first");
            wr_ok(A_SVC, 32'hB480, "R10 service second");
        end
        chk(irq == 1'b0, "R10 no irq while serviced", 32'(irq), 0);
        chk(rst_seen == base, "R10 no reset while serviced", rst_seen, base);

        // R11 wrong words while enabled
        acc(1'b1, A_SVC, 32'h1234, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R11 wrong word enabled");
        wr_ok(A_SVC, 32'hA602, "R11 start sequence");
        acc(1'b1, A_SVC, 32'h5555, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R11 wrong word mid sequence");
        acc(1'b1, A_SVC, 32'hB480, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R11 sequence aborted");
        acc(1'b1, A_SVC, 32'hD928, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R11 unlock out of order");
        wr_ok(A_CTL, 32'h0, "R11 disable");

        // R12 window mode
        wr_ok(A_TMO, 32'd60, "R12 timeout 60");
        wr_ok(A_WIN, 32'd30, "R12 window 30");
        wr_ok(A_CTL, 32'h41, "R12 enable windowed");
        wr_ok(A_SVC, 32'hA602, "R12 early first word");
        acc(1'b1, A_SVC, 32'hB480, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R12 early service rejected");
        repeat (30) @(negedge clk);
        wr_ok(A_SVC, 32'hA602, "R12 late first word");
        wr_ok(A_SVC, 32'hB480, "R12 service inside window");
        repeat (30) @(negedge clk);
        chk(irq == 1'b0, "R12 in-window service reloaded", 32'(irq), 0);
        wr_ok(A_CTL, 32'h0, "R12 disable");

        // R5 reset policy on a bad service word
        wr_ok(A_CTL, 32'h101, "R5 enable with reset policy");
        acc(1'b1, A_SVC, 32'h1, 2'd2, 1'b1, 0, 1'b0, 1'b1, "R5 bad service word gives reset");
        wr_ok(A_CTL, 32'h0, "R5 disable");

        // R7 hard lock
        wr_ok(A_CTL, 32'h20, "R7 set hard lock");
        acc(1'b1, A_TMO, 32'd7, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R7 locked timeout write");
        wr_ok(A_SVC, 32'hC520, "R7 unlock first");
        wr_ok(A_SVC, 32'hD928, "R7 unlock second");
        rd_ok(A_CTL, 32'h20, "R7 hard lock survives unlock");
        acc(1'b1, A_CTL, 32'h0, 2'd2, 1'b1, 0, 1'b1, 1'b0, "R7 control write refused");
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_ok(A_CTL, 32'hFF00_0103, "R7 reset clears hard lock");
        rd_ok(A_TMO, 32'h0002_7100, "R7 timeout back to reset value");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R1 all responses seen", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule